// File: doc/BRIEF.md
# Graphics DRAM Power-State Controller

This block follows the low-power state of a graphics DRAM device. Each clock cycle it looks at the clock-enable pin, a decoded auto-refresh strobe, a flag that is high when every bank is closed, and a flag that is high while a read, write or snoop burst is in flight. From these it keeps one of four power states. It drives enables for the command/address/data input receivers and for the clock receivers. It also pulses a flag when clock-enable is dropped in the middle of a burst.

Dropping clock-enable leads to one of two power-down flavours, picked by whether any bank is open. Self refresh can only be reached through the precharged flavour, or from active by an auto-refresh issued on the same edge as the clock-enable drop. Plain power-down ends on a clock edge. Self refresh reopens the clock receivers as soon as clock-enable rises, with no clock edge involved. The registered state then catches up through a synchronizer.

Top module: `dram_pwr_ctrl`

## Requirements
- R1: Reset leaves the block in the active state (code 00) with both receiver enables high and the violation flag low.
- R2: In the active state, clock-enable sampled low with all banks closed and no auto-refresh moves the state to precharge power-down (code 01) on that edge.
- R3: In the active state, clock-enable sampled low with any bank open moves the state to active power-down (code 10) on that edge, whether auto-refresh is asserted or not.
- R4: Auto-refresh sampled with clock-enable low moves the state to self refresh (code 11) on that edge in two cases: from precharge power-down, and from active with all banks closed.
- R5: In active power-down, auto-refresh has no effect and the state stays 10.
- R6: Either power-down state ends only on a clock edge that samples clock-enable high, and the state is then 00. Between the rise of clock-enable and that edge, the state and the input-receiver enable do not change.
- R7: The input-receiver enable is high only in state 00. The clock-receiver enable is low only in state 11 while clock-enable is low.
- R8: In self refresh, a rise of clock-enable drives the clock-receiver enable high at once, with no clock edge.
- R9: Self-refresh exit reaches the registered state through a synchronizer of SYNC_STAGES flops. With clock-enable held high, the state stays 11 for the first SYNC_STAGES edges and becomes 00 on the next one.
- R10: Clock-enable sampled low in state 00 while a burst is active raises the violation flag for exactly the following cycle. In every other case the flag is low.
- R11: In self refresh with clock-enable low, the auto-refresh and bank-status inputs have no effect and the state stays 11.
- R12: Auto-refresh with clock-enable high leaves the active state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Device clock-enable level |
| aref_i | input | 1 | Decoded auto-refresh command strobe |
| banks_idle_i | input | 1 | High when every bank is precharged |
| burst_act_i | input | 1 | High while a read, write or snoop burst is active |
| pwr_state_o | output | 2 | 00 active, 01 precharge power-down, 10 active power-down, 11 self refresh |
| in_rcv_en_o | output | 1 | Enable for the non-clock input receivers |
| clk_rcv_en_o | output | 1 | Enable for the clock receivers |
| viol_o | output | 1 | One-cycle pulse: clock-enable dropped during a burst |

## Verification
The assertions assume that clock-enable moves only between clock edges. They also assume that after it rises out of self refresh, it stays high until the synchronizer has carried it into the state. The stimulus changes every input on the falling clock edge. It holds clock-enable high for SYNC_STAGES+1 edges on every self-refresh exit. The bank-status and burst flags act as free inputs, and the bench sweeps all of their combinations at each power-down entry.

// File: rtl/dpwr_pkg.sv
`timescale 1ns/1ps
package dpwr_pkg;
  typedef enum logic [1:0] {
    PS_ACT = 2'b00,
    PS_PPD = 2'b01,
    PS_APD = 2'b10,
    PS_SR  = 2'b11
  } pwr_state_e;
endpackage

// File: rtl/dpwr_cke_sync.sv
`timescale 1ns/1ps
module dpwr_cke_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic stage_q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    stage_q <= 1'b0;
        else if (clr_i) stage_q <= 1'b0;
        else            stage_q <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    stage_q <= 1'b0;
        else if (clr_i) stage_q <= 1'b0;
        else            stage_q <= g_stage[g-1].stage_q;
      end
    end
  end

  assign q_o = g_stage[STAGES-1].stage_q;
endmodule

// File: rtl/dpwr_fsm.sv
`timescale 1ns/1ps
module dpwr_fsm
  import dpwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cke_i,
  input  logic       cke_sync_i,
  input  logic       aref_i,
  input  logic       banks_idle_i,
  output pwr_state_e state_o,
  output logic       sr_entry_o
);
  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_ACT: if (!cke_i) begin
        if (banks_idle_i) state_d = aref_i ? PS_SR : PS_PPD;
        else              state_d = PS_APD;
      end
      PS_PPD: if (cke_i) state_d = PS_ACT;
              else if (aref_i) state_d = PS_SR;
      PS_APD: if (cke_i) state_d = PS_ACT;  // refresh refused with open banks
      PS_SR:  if (cke_sync_i) state_d = PS_ACT;
      default: state_d = PS_ACT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PS_ACT;
    else         state_q <= state_d;
  end

  // flush the synchronizer so a stale high cannot end self refresh early
  assign sr_entry_o = (state_d == PS_SR) && (state_q != PS_SR);
  assign state_o    = state_q;
endmodule

// File: rtl/dpwr_viol_mon.sv
`timescale 1ns/1ps
module dpwr_viol_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic cke_i,
  input  logic burst_act_i,
  output logic viol_o
);
  logic viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= active_i && !cke_i && burst_act_i;
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/dram_pwr_ctrl.sv
`timescale 1ns/1ps
module dram_pwr_ctrl
  import dpwr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cke_i,
  input  logic       aref_i,
  input  logic       banks_idle_i,
  input  logic       burst_act_i,
  output logic [1:0] pwr_state_o,
  output logic       in_rcv_en_o,
  output logic       clk_rcv_en_o,
  output logic       viol_o
);
  pwr_state_e state;
  logic       cke_sync;
  logic       sr_entry;

  dpwr_cke_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sr_entry),
    .d_i    (cke_i),
    .q_o    (cke_sync)
  );

  dpwr_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cke_i        (cke_i),
    .cke_sync_i   (cke_sync),
    .aref_i       (aref_i),
    .banks_idle_i (banks_idle_i),
    .state_o      (state),
    .sr_entry_o   (sr_entry)
  );

  dpwr_viol_mon i_viol (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (state == PS_ACT),
    .cke_i       (cke_i),
    .burst_act_i (burst_act_i),
    .viol_o      (viol_o)
  );

  assign pwr_state_o  = state;
  assign in_rcv_en_o  = (state == PS_ACT);
  // async wake of the clock receivers on CKE rise
  assign clk_rcv_en_o = (state != PS_SR) || cke_i;
endmodule

// File: rtl/dpwr_chk.sv
`timescale 1ns/1ps
module dpwr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cke_i,
  input logic       aref_i,
  input logic       banks_idle_i,
  input logic       burst_act_i,
  input logic [1:0] pwr_state_o,
  input logic       in_rcv_en_o,
  input logic       clk_rcv_en_o,
  input logic       viol_o
);
  AST_ACT_TO_PPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'b00 && !cke_i && banks_idle_i && !aref_i) |=> pwr_state_o == 2'b01); // R2
  AST_ACT_TO_APD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'b00 && !cke_i && !banks_idle_i) |=> pwr_state_o == 2'b10); // R3
  AST_PPD_TO_SR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'b01 && !cke_i && aref_i) |=> pwr_state_o == 2'b11); // R4
  AST_APD_NO_SR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'b10) |=> pwr_state_o != 2'b11); // R5
  AST_PD_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwr_state_o == 2'b01 || pwr_state_o == 2'b10) && cke_i) |=> pwr_state_o == 2'b00); // R6
  AST_PD_RCV_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'b00 && !cke_i) |=> !in_rcv_en_o); // R7
  AST_SR_CLK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'b11 && !cke_i) |-> !clk_rcv_en_o); // R7
  AST_VIOL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'b00 && !cke_i && burst_act_i) |=> viol_o); // R10
  AST_NO_FALSE_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o != 2'b00 || cke_i || !burst_act_i) |=> !viol_o); // R10
  AST_AREF_CKE_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'b00 && cke_i) |=> pwr_state_o == 2'b00); // R12
endmodule

bind dram_pwr_ctrl dpwr_chk i_chk (.*);

// File: tb/test_dram_pwr_ctrl.sv
`timescale 1ns/1ps
module test_dram_pwr_ctrl;
  localparam int unsigned SYNC_STAGES = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cke_i = 1'b1;
  logic       aref_i = 1'b0;
  logic       banks_idle_i = 1'b1;
  logic       burst_act_i = 1'b0;
  logic [1:0] pwr_state_o;
  logic       in_rcv_en_o;
  logic       clk_rcv_en_o;
  logic       viol_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dram_pwr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_dram_pwr_ctrl (.*);

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic drv(input logic cke, input logic aref, input logic idle, input logic burst);
    @(negedge clk_i);
    cke_i = cke; aref_i = aref; banks_idle_i = idle; burst_act_i = burst;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #35 rst_ni = 1'b1;
    tick();
    // R1
    check("R1 state", pwr_state_o, 2'b00);
    check("R1 in_rcv", {1'b0, in_rcv_en_o}, 2'b01);
    check("R1 clk_rcv", {1'b0, clk_rcv_en_o}, 2'b01);
    check("R1 viol", {1'b0, viol_o}, 2'b00);

    // R12: refresh and bursts with CKE high keep active, no violation
    for (int k = 0; k < 4; k++) begin
      drv(1'b1, 1'b1, k[0], k[1]);
      tick();
      check("R12 state", pwr_state_o, 2'b00);
      check("R10 no viol cke high", {1'b0, viol_o}, 2'b00);
    end

    for (int rep = 0; rep < 2; rep++) begin
      for (int c = 0; c < 8; c++) begin
        logic idle, burst, aref;
        logic [1:0] exp;
        idle = c[0]; burst = c[1]; aref = c[2];
        exp = !idle ? 2'b10 : (aref ? 2'b11 : 2'b01);
        drv(1'b0, aref, idle, burst);
        tick();
        check(idle ? (aref ? "R4 act->sr" : "R2 act->ppd") : "R3 act->apd", pwr_state_o, exp);
        check("R10 viol", {1'b0, viol_o}, {1'b0, burst});
        check("R7 in_rcv off", {1'b0, in_rcv_en_o}, 2'b00);
        check("R7 clk_rcv", {1'b0, clk_rcv_en_o}, {1'b0, exp != 2'b11});
        drv(1'b0, 1'b0, idle, 1'b1);
        tick();
        check("R10 pulse ends", {1'b0, viol_o}, 2'b00);
        check("R6 hold low", pwr_state_o, exp);
        if (exp == 2'b10) begin
          drv(1'b0, 1'b1, 1'b1, 1'b0);
          tick();
          check("R5 apd refresh ignored", pwr_state_o, 2'b10);
        end else if (exp == 2'b01) begin
          drv(1'b0, 1'b1, 1'b1, 1'b0);
          tick();
          check("R4 ppd->sr", pwr_state_o, 2'b11);
          exp = (rep == 0) ? 2'b11 : 2'b01;
          if (rep == 1) begin
            // leave from ppd instead: a real exit needs a fresh entry
            drv(1'b1, 1'b0, 1'b1, 1'b0);
            for (int s = 0; s < SYNC_STAGES; s++) tick();
            tick();
            check("R9 sr exit", pwr_state_o, 2'b00);
            drv(1'b0, 1'b0, 1'b1, 1'b0);
            tick();
            check("R2 act->ppd again", pwr_state_o, 2'b01);
          end
        end
        if (exp == 2'b11) begin
          drv(1'b0, 1'b1, ~idle, 1'b1);
          tick();
          check("R11 sr holds", pwr_state_o, 2'b11);
          check("R7 sr clk_rcv off", {1'b0, clk_rcv_en_o}, 2'b00);
          drv(1'b1, 1'b0, 1'b1, 1'b0);
          #1;
          check("R8 async clk wake", {1'b0, clk_rcv_en_o}, 2'b01);
          check("R8 state unchanged", pwr_state_o, 2'b11);
          for (int s = 0; s < SYNC_STAGES; s++) begin
            tick();
            check("R9 sync wait", pwr_state_o, 2'b11);
          end
          tick();
          check("R9 sr exit", pwr_state_o, 2'b00);
          check("R7 in_rcv on", {1'b0, in_rcv_en_o}, 2'b01);
        end else begin
          drv(1'b1, 1'b0, 1'b1, 1'b0);
          #1;
          check("R6 no exit before edge", pwr_state_o, exp);
          check("R6 in_rcv still off", {1'b0, in_rcv_en_o}, 2'b00);
          tick();
          check("R6 pd exit", pwr_state_o, 2'b00);
          check("R7 in_rcv on", {1'b0, in_rcv_en_o}, 2'b01);
        end
        check("R10 no viol after exit", {1'b0, viol_o}, 2'b00);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule